// File: doc/BRIEF.md
# Serial Command Receiver for Amplifier Control

This block receives single-byte control commands over a three-wire, write-only serial port. The port has an active-low enable, a clock and a data line. A fast system clock oversamples all three lines. The received byte is decoded into three controls for an audio amplifier: a run/shutdown flag, an unmute flag and a 5-bit volume code. The block keeps these controls in a register set that it shares with a second, two-wire control path. A static owner select decides which of the two paths may write the register set.

Each time the enable line goes low, a new window opens. Data bits are taken on the rising edges of the serial clock, most significant bit first. A command takes effect on the eighth rising edge of the window. Any further clocks in the same window are discarded. If the window closes before the eighth bit arrives, the partial byte is dropped.

The two-wire path already delivers whole bytes, as a one-cycle write strobe with a byte. This block applies those bytes with the same decode.

Top module: `spi_cmd_rx`

## Requirements
- R1: After reset, amp_run is 0 (shut down), amp_unmute is 0 (muted) and vol_code is 0.
- R2: Data is taken on each rising serial clock edge while spi_en_n is low, most significant bit first.
- R3: A serial command reaches the outputs three system clocks after the system edge that first samples the eighth rising serial clock edge: two synchroniser stages, an edge register and the control register.
- R4: Rising clock edges after the eighth in the same window have no effect.
- R5: A window that closes after fewer than eight rising clock edges changes no output.
- R6: A byte with bit 7 = 0 and bit 5 = 0 is a mode byte. Its bit 0 drives amp_run (1 = run) and its bit 1 drives amp_unmute (1 = unmuted). The volume is unchanged.
- R7: A byte with bits 7:5 = 100 is a volume byte. Its bits 4:0 load vol_code. The mode flags are unchanged.
- R8: A byte that matches neither pattern changes no output.
- R9: With port_sel = 0, an i2c_wr strobe applies i2c_byte at the same system edge, and serial commands are ignored.
- R10: With port_sel = 1, i2c_wr strobes are ignored.
- R11: Every window starts with an empty shift register and bit count, so bits from an aborted window never join a later command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| port_sel | input | 1 | Owner select: 1 = serial port, 0 = two-wire path |
| spi_en_n | input | 1 | Serial enable, active low, asynchronous |
| spi_clk | input | 1 | Serial clock, asynchronous |
| spi_dat | input | 1 | Serial data, asynchronous |
| i2c_wr | input | 1 | One-cycle byte strobe from the two-wire path |
| i2c_byte | input | 8 | Byte from the two-wire path |
| amp_run | output | 1 | 1 = amplifier running, 0 = shut down |
| amp_unmute | output | 1 | 1 = audio passes, 0 = muted |
| vol_code | output | 5 | Volume code |

## Verification
A serial command is due three system clocks after the bench itself first sees the eighth rising serial edge. A two-wire byte is due at the edge that samples its strobe. The reference model in the bench samples the raw pins at each rising system edge. It holds each serial command in a three-deep queue before applying it, and applies two-wire bytes at once. The outputs are compared with the model on every falling edge, so a change that arrives one cycle early or late is caught. Directed checks after each transfer confirm the settled values for each corner case.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;

  localparam int CMD_W = 8;
  localparam int VOL_W = 5;

  typedef struct packed {
    logic             run;
    logic             unmute;
    logic [VOL_W-1:0] vol;
  } ctl_t;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_MODE = 2'd1,
    K_VOL  = 2'd2
  } kind_e;

  localparam ctl_t CTL_RESET = '{run: 1'b0, unmute: 1'b0, vol: '0};

  // Top three bits select the command class; mode needs bits 7 and 5 clear.
  function automatic kind_e classify(input logic [CMD_W-1:0] b);
    kind_e k;
    if (!b[CMD_W-1] && !b[CMD_W-3])         k = K_MODE;
    else if (b[CMD_W-1 -: 3] == 3'b100)     k = K_VOL;
    else                                    k = K_NONE;
    return k;
  endfunction

endpackage

// File: rtl/spicmd_sync.sv
module spicmd_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[0] <= RST_VAL;
        else     st[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[g] <= RST_VAL;
        else     st[g] <= st[g-1];
      end
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/spicmd_shift.sv
module spicmd_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_n,
  input  logic         sclk,
  input  logic         sdat,
  output logic         cmd_valid,
  output logic [W-1:0] cmd_byte
);

  localparam int CNT_W = $clog2(W + 1);

  logic             clk_q;
  logic             en_q;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     sh;
  logic             rise;
  logic             win_open;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q <= 1'b0;
      en_q  <= 1'b1;
    end else begin
      clk_q <= sclk;
      en_q  <= en_n;
    end
  end

  assign rise     = sclk & ~clk_q;
  assign win_open = ~en_n & en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      sh        <= '0;
      cmd_valid <= 1'b0;
      cmd_byte  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (en_n) begin
        cnt <= '0;
      end else if (win_open) begin
        cnt <= '0;
        sh  <= '0;
      end else if (rise && (cnt < CNT_W'(W))) begin
        sh  <= {sh[W-2:0], sdat};
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(W - 1)) begin
          cmd_valid <= 1'b1;
          cmd_byte  <= {sh[W-2:0], sdat};
        end
      end
    end
  end

  // R4: the bit count never passes the command length
  a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(W));

  // R5: a commit only follows a sampled edge inside an open window
  a_r5_commit_in_window: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(!en_n));

  // R3: a commit is a single-cycle pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  // R11: a new window leaves the count empty
  a_r11_fresh_window: assert property (@(posedge clk) disable iff (rst)
    win_open |=> (cnt == '0));

endmodule

// File: rtl/spicmd_regs.sv
module spicmd_regs
  import spicmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             spi_v,
  input  logic [CMD_W-1:0] spi_b,
  input  logic             i2c_v,
  input  logic [CMD_W-1:0] i2c_b,
  output ctl_t             ctl
);

  logic             wr_v;
  logic [CMD_W-1:0] wr_b;
  kind_e            kind;
  ctl_t             ctl_q;

  always_comb begin
    if (sel) begin
      wr_v = spi_v;
      wr_b = spi_b;
    end else begin
      wr_v = i2c_v;
      wr_b = i2c_b;
    end
    kind = classify(wr_b);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= CTL_RESET;
    end else if (wr_v) begin
      case (kind)
        K_MODE: begin
          ctl_q.run    <= wr_b[0];
          ctl_q.unmute <= wr_b[1];
        end
        K_VOL:   ctl_q.vol <= wr_b[VOL_W-1:0];
        default: ctl_q     <= ctl_q;
      endcase
    end
  end

  assign ctl = ctl_q;

  // R7: an owned volume byte loads the code on the next edge
  a_r7_vol_load: assert property (@(posedge clk) disable iff (rst)
    (sel && spi_v && spi_b[CMD_W-1 -: 3] == 3'b100) |=> (ctl_q.vol == $past(spi_b[VOL_W-1:0])));

  // R10: two-wire bytes cannot touch the registers while the serial port owns them
  a_r10_i2c_blocked: assert property (@(posedge clk) disable iff (rst)
    (sel && i2c_v && !spi_v) |=> $stable(ctl_q));

  // R9: serial commands cannot touch the registers while the two-wire path owns them
  a_r9_spi_blocked: assert property (@(posedge clk) disable iff (rst)
    (!sel && spi_v && !i2c_v) |=> $stable(ctl_q));

  // R8: a byte of neither class leaves every control unchanged
  a_r8_ignore_other: assert property (@(posedge clk) disable iff (rst)
    (wr_v && kind == K_NONE) |=> $stable(ctl_q));

endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
  import spicmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             port_sel,
  input  logic             spi_en_n,
  input  logic             spi_clk,
  input  logic             spi_dat,
  input  logic             i2c_wr,
  input  logic [CMD_W-1:0] i2c_byte,
  output logic             amp_run,
  output logic             amp_unmute,
  output logic [VOL_W-1:0] vol_code
);

  logic [2:0]       pins_s;
  logic             cmd_valid;
  logic [CMD_W-1:0] cmd_byte;
  ctl_t             ctl;

  // bit order {clk, en_n, dat}; enable idles high
  spicmd_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b010)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_clk, spi_en_n, spi_dat}),
    .q   (pins_s)
  );

  spicmd_shift #(
    .W (CMD_W)
  ) u_shift (
    .clk       (clk),
    .rst       (rst),
    .en_n      (pins_s[1]),
    .sclk      (pins_s[2]),
    .sdat      (pins_s[0]),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte)
  );

  spicmd_regs u_regs (
    .clk   (clk),
    .rst   (rst),
    .sel   (port_sel),
    .spi_v (cmd_valid),
    .spi_b (cmd_byte),
    .i2c_v (i2c_wr),
    .i2c_b (i2c_byte),
    .ctl   (ctl)
  );

  assign amp_run    = ctl.run;
  assign amp_unmute = ctl.unmute;
  assign vol_code   = ctl.vol;

endmodule

// File: tb/spi_cmd_rx_test.sv
`timescale 1ns/100ps
module spi_cmd_rx_test;

  localparam int H = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       port_sel = 1'b1;
  logic       spi_en_n = 1'b1;
  logic       spi_clk = 1'b0;
  logic       spi_dat = 1'b0;
  logic       i2c_wr = 1'b0;
  logic [7:0] i2c_byte = 8'h00;
  logic       amp_run;
  logic       amp_unmute;
  logic [4:0] vol_code;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  spi_cmd_rx uut (
    .clk        (clk),
    .rst        (rst),
    .port_sel   (port_sel),
    .spi_en_n   (spi_en_n),
    .spi_clk    (spi_clk),
    .spi_dat    (spi_dat),
    .i2c_wr     (i2c_wr),
    .i2c_byte   (i2c_byte),
    .amp_run    (amp_run),
    .amp_unmute (amp_unmute),
    .vol_code   (vol_code)
  );

  // reference model
  int m_run = 0, m_unm = 0, m_vol = 0;
  int m_cnt = 0, m_sh = 0, m_prev = 0;
  int pv [3] = '{0, 0, 0};
  int pb [3] = '{0, 0, 0};

  task automatic m_apply(input int b);
    if (((b >> 7) & 1) == 0 && ((b >> 5) & 1) == 0) begin
      m_run = b & 1;
      m_unm = (b >> 1) & 1;
    end else if ((b >> 5) == 4) begin
      m_vol = b & 31;
    end
  endtask

  always @(posedge clk) begin
    int dv, db;
    if (rst) begin
      m_run = 0; m_unm = 0; m_vol = 0;
      m_cnt = 0; m_sh = 0; m_prev = 0;
      foreach (pv[i]) begin pv[i] = 0; pb[i] = 0; end
    end else begin
      if (pv[2] != 0 && port_sel) m_apply(pb[2]);
      if (i2c_wr && !port_sel) m_apply(int'(i2c_byte));
      dv = 0; db = 0;
      if (spi_en_n) begin
        m_cnt = 0; m_sh = 0;
      end else if (spi_clk && m_prev == 0 && m_cnt < 8) begin
        m_sh = ((m_sh << 1) | int'(spi_dat)) & 255;
        m_cnt++;
        if (m_cnt == 8) begin dv = 1; db = m_sh; end
      end
      m_prev = int'(spi_clk);
      pv[2] = pv[1]; pb[2] = pb[1];
      pv[1] = pv[0]; pb[1] = pb[0];
      pv[0] = dv;    pb[0] = db;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R3: cycle-exact comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R3 run timing", int'(amp_run), m_run);
      check("R3 unmute timing", int'(amp_unmute), m_unm);
      check("R3 vol timing", int'(vol_code), m_vol);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic spi_send(input logic [7:0] b, input int nbits);
    @(negedge clk) spi_en_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_dat = (i < 8) ? b[7-i] : 1'b1;
      repeat (H) @(negedge clk);
      spi_clk = 1'b1;
      repeat (H) @(negedge clk);
      spi_clk = 1'b0;
    end
    repeat (H) @(negedge clk);
    spi_en_n = 1'b1;
    repeat (4 * H) @(negedge clk);
  endtask

  task automatic i2c_send(input logic [7:0] b);
    @(negedge clk);
    i2c_wr = 1'b1;
    i2c_byte = b;
    @(negedge clk);
    i2c_wr = 1'b0;
  endtask

  task automatic expect_ctl(input string tag, input int r, input int u, input int v);
    check(tag, int'(amp_run), r);
    check(tag, int'(amp_unmute), u);
    check(tag, int'(vol_code), v);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_ctl("R1 reset state", 0, 0, 0);

    spi_send(8'h03, 8);
    expect_ctl("R6 mode run+unmute", 1, 1, 0);

    spi_send(8'h95, 8);
    expect_ctl("R7 R2 volume msb first", 1, 1, 21);

    spi_send(8'h01, 8);
    expect_ctl("R6 mode mute", 1, 0, 21);

    spi_send(8'h9F, 5);
    expect_ctl("R5 short window aborted", 1, 0, 21);

    spi_send(8'hFF, 3);
    spi_send(8'h8A, 8);
    expect_ctl("R11 window starts fresh", 1, 0, 10);

    spi_send(8'h87, 12);
    expect_ctl("R4 extra clocks ignored", 1, 0, 7);

    spi_send(8'hA0, 8);
    expect_ctl("R8 class 101 ignored", 1, 0, 7);
    spi_send(8'h20, 8);
    expect_ctl("R8 bit5 set ignored", 1, 0, 7);

    i2c_send(8'h9F);
    expect_ctl("R10 two-wire blocked", 1, 0, 7);

    port_sel = 1'b0;
    i2c_send(8'h83);
    expect_ctl("R9 two-wire volume same edge", 1, 0, 3);
    i2c_send(8'h02);
    expect_ctl("R9 two-wire mode", 0, 1, 3);
    spi_send(8'h9E, 8);
    expect_ctl("R9 serial blocked", 0, 1, 3);

    port_sel = 1'b1;
    repeat (2) @(negedge clk);
    spi_send(8'h9E, 8);
    expect_ctl("R7 serial owns again", 0, 1, 30);

    repeat (10) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule